// File: doc/BRIEF.md
# Write-Back Victim Holding Buffer with Bus Snooping

This block sits beside a direct-mapped write-back cache and holds a single evicted line. A read miss can displace a resident line that has the same index but a different tag. If that line is dirty, its line address and data are latched here so that the new line can be filled at once. The held line is written back to memory over a request/acknowledge port. That writeback is allowed only after the read miss that caused the eviction has reported completion, and it starts in the first cycle after that.

While a line is held, the buffer acts as a second, one-line way of the cache for coherence. A bus read to the held line address is answered in the same cycle with the held data. A bus write to that address, arriving before the writeback request is raised, discards the entry, so the stale copy never reaches memory. The processor read path gets no acknowledge while the entry is occupied. A capture and an invalidating bus write to the same address in the same cycle are resolved by comparing transaction tags.

Each processor has one instance. The line is `WORDS` words of `WORD_W` bits, and addresses are line addresses (tag and index together).

Top module: `victim_buffer`

## Requirements
- R1: A line is captured only in a cycle where `cap_valid`, `cap_dirty` and `cap_tag_diff` are all 1 and the buffer is empty. With any of the three at 0, the buffer stays empty and `cpu_rd_ack` follows `cpu_rd_req` in the next cycle.
- R2: Capacity is one line. A capture offered while the buffer is occupied is ignored, and the held address and data stay unchanged.
- R3: When `snp_valid`=1, `snp_write`=0 and `snp_addr` equals the held line address, `snp_hit` is 1 in that same cycle and `snp_data` carries the held line (word 0 in bits [WORD_W-1:0]). Otherwise `snp_hit` is 0 and `snp_data` is all zeros.
- R4: A bus write (`snp_valid`=1, `snp_write`=1) to the held address in a cycle where `mem_req` is 0 empties the buffer at that clock edge. No writeback of that line is ever requested.
- R5: `mem_req` stays 0 from the capture until `miss_done` is sampled high at a clock edge after the capture edge. It is 1 in the cycle that follows that edge. A `miss_done` in the capture cycle itself is ignored.
- R6: `cpu_rd_ack` equals `cpu_rd_req` while the buffer is empty and is 0 while it is occupied.
- R7: Once raised, `mem_req` stays 1 with stable `mem_addr` and `mem_data` until `mem_ack`. The buffer is empty after the edge that samples `mem_req` and `mem_ack` both 1. Bus writes while `mem_req` is 1 do not cancel the writeback, and bus reads still hit.
- R8: If a capture coincides with a bus write to the same address, the capture is kept only when `snp_txn` is numerically less than `cap_txn` (the bus write is older). On equal or greater tags, the capture is discarded.
- R9: After reset the buffer is empty, `mem_req` and `snp_hit` are 0, and `cpu_rd_ack` follows `cpu_rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | An eviction is offered this cycle |
| cap_dirty | input | 1 | The displaced line is dirty |
| cap_tag_diff | input | 1 | The incoming line's tag differs from the displaced line's |
| cap_addr | input | ADDR_W | Line address of the displaced line |
| cap_data | input | WORDS*WORD_W | Data of the displaced line |
| cap_txn | input | TXN_W | Transaction tag of the causing miss |
| miss_done | input | 1 | The causing read miss has completed |
| cpu_rd_req | input | 1 | Processor read request |
| cpu_rd_ack | output | 1 | Processor read accepted |
| snp_valid | input | 1 | Bus transaction present |
| snp_write | input | 1 | Bus transaction is a write |
| snp_addr | input | ADDR_W | Bus line address |
| snp_txn | input | TXN_W | Bus transaction tag |
| snp_hit | output | 1 | Bus read hits the held line |
| snp_data | output | WORDS*WORD_W | Held line data for a hitting read |
| mem_req | output | 1 | Writeback request |
| mem_addr | output | ADDR_W | Writeback line address |
| mem_data | output | WORDS*WORD_W | Writeback line data |
| mem_ack | input | 1 | Memory accepts the writeback |

## Verification
The assertions check these properties on every cycle: the writeback stays quiet in the cycle after a capture, the request holds steady until acknowledged, and the entry is freed by an acknowledge or by an early bus write. They also check that processor reads are refused while a line is held and that a snoop hit only ever returns the held line. Some behaviour can only be shown by the bench's scenarios. These are that clean or same-tag evictions leave no trace, that a second capture is dropped, that a cancelled line never reaches memory, and that the transaction tag decides a same-cycle collision. The bench covers them by running sequences against its reference model and counting the completed writebacks.

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ADDR_W = 26,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int TXN_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_valid,
  input  logic                     cap_dirty,
  input  logic                     cap_tag_diff,
  input  logic [ADDR_W-1:0]        cap_addr,
  input  logic [WORDS*WORD_W-1:0]  cap_data,
  input  logic [TXN_W-1:0]         cap_txn,
  input  logic                     miss_done,
  input  logic                     cpu_rd_req,
  output logic                     cpu_rd_ack,
  input  logic                     snp_valid,
  input  logic                     snp_write,
  input  logic [ADDR_W-1:0]        snp_addr,
  input  logic [TXN_W-1:0]         snp_txn,
  output logic                     snp_hit,
  output logic [WORDS*WORD_W-1:0]  snp_data,
  output logic                     mem_req,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [WORDS*WORD_W-1:0]  mem_data,
  input  logic                     mem_ack
);
  localparam int LINE_W = WORDS * WORD_W;

  logic              vld, pend;
  logic [ADDR_W-1:0] held_addr;
  logic [LINE_W-1:0] held_data;

  logic take, clash, match, kill, retire;

  assign take   = cap_valid & cap_dirty & cap_tag_diff & ~vld;
  assign clash  = snp_valid & snp_write & (snp_addr == cap_addr) & ~(snp_txn < cap_txn);
  assign match  = snp_valid & vld & (snp_addr == held_addr);
  assign kill   = match & snp_write & ~mem_req;
  assign retire = mem_req & mem_ack;

  assign mem_req    = vld & ~pend;
  assign mem_addr   = held_addr;
  assign mem_data   = held_data;
  assign cpu_rd_ack = cpu_rd_req & ~vld;
  assign snp_hit    = match & ~snp_write;
  assign snp_data   = snp_hit ? held_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= 1'b0;
      pend      <= 1'b0;
      held_addr <= '0;
      held_data <= '0;
    end else if (vld) begin
      if (retire || kill) vld  <= 1'b0;
      else if (miss_done) pend <= 1'b0;
    end else if (take && !clash) begin
      vld       <= 1'b1;
      pend      <= 1'b1;
      held_addr <= cap_addr;
      held_data <= cap_data;
    end
  end
endmodule

// File: rtl/victim_buffer_chk.sv
module victim_buffer_chk #(
  parameter int ADDR_W = 26,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int TXN_W  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     vld,
  input logic                     cap_valid,
  input logic                     cap_dirty,
  input logic                     cap_tag_diff,
  input logic                     cpu_rd_ack,
  input logic                     snp_valid,
  input logic                     snp_write,
  input logic [ADDR_W-1:0]        snp_addr,
  input logic                     snp_hit,
  input logic [WORDS*WORD_W-1:0]  snp_data,
  input logic                     mem_req,
  input logic [ADDR_W-1:0]        mem_addr,
  input logic [WORDS*WORD_W-1:0]  mem_data,
  input logic                     mem_ack
);
  // R5
  quiet_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_dirty && cap_tag_diff && !vld) |=> !mem_req);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

  // R7
  free_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !vld);

  // R4
  early_write_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !mem_req && snp_valid && snp_write && snp_addr == mem_addr) |=> !vld);

  // R6
  stall_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> !cpu_rd_ack);

  // R3
  hit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit |-> (snp_valid && !snp_write && vld && snp_data == mem_data));

  // R2
  full_keeps_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !(mem_req && mem_ack)) |=> ($stable(mem_addr) && $stable(mem_data)));
endmodule

bind victim_buffer victim_buffer_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .TXN_W(TXN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vld(vld),
  .cap_valid(cap_valid), .cap_dirty(cap_dirty), .cap_tag_diff(cap_tag_diff),
  .cpu_rd_ack(cpu_rd_ack),
  .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
  .snp_hit(snp_hit), .snp_data(snp_data),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack)
);

// File: tb/victim_buffer_bench.sv
`timescale 1ns/1ps
module victim_buffer_bench;
  localparam int ADDR_W = 26, WORD_W = 32, WORDS = 4, TXN_W = 4;
  localparam int LINE_W = WORDS * WORD_W;

  logic clk = 0, rst_n = 0;
  logic cap_valid = 0, cap_dirty = 0, cap_tag_diff = 0;
  logic [ADDR_W-1:0] cap_addr = '0;
  logic [LINE_W-1:0] cap_data = '0;
  logic [TXN_W-1:0]  cap_txn = '0;
  logic miss_done = 0, cpu_rd_req = 0, cpu_rd_ack;
  logic snp_valid = 0, snp_write = 0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [TXN_W-1:0]  snp_txn = '0;
  logic snp_hit, mem_req, mem_ack = 0;
  logic [LINE_W-1:0] snp_data, mem_data;
  logic [ADDR_W-1:0] mem_addr;

  victim_buffer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .TXN_W(TXN_W)) u_victim_buffer (
    .clk, .rst_n, .cap_valid, .cap_dirty, .cap_tag_diff, .cap_addr, .cap_data, .cap_txn,
    .miss_done, .cpu_rd_req, .cpu_rd_ack, .snp_valid, .snp_write, .snp_addr, .snp_txn,
    .snp_hit, .snp_data, .mem_req, .mem_addr, .mem_data, .mem_ack);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  // reference model state
  bit m_vld = 0, m_pend = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [LINE_W-1:0] m_data = '0;
  int wcnt = 0, lat = 0, nwb = 0;
  logic [ADDR_W-1:0] wb_log[$];

  task automatic chk(bit ok, string req, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [LINE_W-1:0] line(int seed);
    logic [LINE_W-1:0] v;
    for (int w = 0; w < WORDS; w++) v[w*WORD_W +: WORD_W] = 32'(seed * 4099 + w * 17 + 1);
    return v;
  endfunction

  task automatic cyc();
    bit mreq, eh, sw_hit;
    mreq = m_vld && !m_pend;
    mem_ack = mreq && (wcnt >= lat);
    #1;
    chk(cpu_rd_ack === (cpu_rd_req && !m_vld), "R6", LINE_W'(cpu_rd_ack), LINE_W'(cpu_rd_req && !m_vld));
    chk(mem_req === mreq, "R5", LINE_W'(mem_req), LINE_W'(mreq));
    if (mreq) begin
      chk(mem_addr === m_addr, "R7", LINE_W'(mem_addr), LINE_W'(m_addr));
      chk(mem_data === m_data, "R7", mem_data, m_data);
    end
    eh = snp_valid && !snp_write && m_vld && snp_addr == m_addr;
    chk(snp_hit === eh, "R3", LINE_W'(snp_hit), LINE_W'(eh));
    chk(snp_data === (eh ? m_data : '0), "R3", snp_data, eh ? m_data : '0);
    if (mem_req && mem_ack) begin nwb++; wb_log.push_back(mem_addr); end
    @(posedge clk);
    sw_hit = snp_valid && snp_write && m_vld && snp_addr == m_addr;
    if (m_vld) begin
      if (mreq && mem_ack) m_vld = 0;
      else if (!mreq && sw_hit) m_vld = 0;
      else if (m_pend && miss_done) m_pend = 0;
    end else if (cap_valid && cap_dirty && cap_tag_diff) begin
      if (!(snp_valid && snp_write && snp_addr == cap_addr && !(snp_txn < cap_txn))) begin
        m_vld = 1; m_pend = 1; m_addr = cap_addr; m_data = cap_data;
      end
    end
    wcnt = (mreq && !mem_ack) ? wcnt + 1 : 0;
    @(negedge clk);
    cap_valid = 0; miss_done = 0; snp_valid = 0; snp_write = 0;
  endtask

  task automatic offer(logic [ADDR_W-1:0] a, int seed, bit d, bit td, logic [TXN_W-1:0] t);
    cap_valid = 1; cap_dirty = d; cap_tag_diff = td; cap_addr = a; cap_data = line(seed); cap_txn = t;
  endtask

  task automatic snoop(logic [ADDR_W-1:0] a, bit w, logic [TXN_W-1:0] t);
    snp_valid = 1; snp_write = w; snp_addr = a; snp_txn = t;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    cpu_rd_req = 1;
    @(negedge clk);
    #1;
    // R9 reset state
    chk(mem_req === 0 && snp_hit === 0 && cpu_rd_ack === 1, "R9", LINE_W'({mem_req, snp_hit, cpu_rd_ack}), LINE_W'(3'b001));
    rst_n = 1;
    @(negedge clk);
    // R1 clean line and same-tag line are dropped
    offer(26'h100, 1, 0, 1, 1); cyc();
    offer(26'h101, 2, 1, 0, 1); cyc();
    #1 chk(cpu_rd_ack === 1 && mem_req === 0, "R1", LINE_W'({cpu_rd_ack, mem_req}), LINE_W'(2'b10));
    repeat (2) cyc();
    // R5 capture A, miss_done in capture cycle ignored
    lat = 2;
    offer(26'h0A0, 10, 1, 1, 3); miss_done = 1; cyc();
    #1 chk(mem_req === 0 && cpu_rd_ack === 0, "R5", LINE_W'({mem_req, cpu_rd_ack}), LINE_W'(0));
    snoop(26'h0A0, 0, 0); cyc();
    snoop(26'h0A1, 0, 0); cyc();
    // R2 capture while full ignored
    offer(26'h0B0, 11, 1, 1, 4); cyc();
    snoop(26'h0A0, 0, 0);
    #1 chk(snp_data === line(10), "R2", snp_data, line(10));
    cyc();
    miss_done = 1; cyc();
    #1 chk(mem_req === 1 && mem_addr === 26'h0A0, "R5", LINE_W'(mem_addr), LINE_W'(26'h0A0));
    // R7 write during request does not cancel; read still hits
    snoop(26'h0A0, 1, 0); cyc();
    snoop(26'h0A0, 0, 0); cyc();
    repeat (3) cyc();
    #1 chk(nwb == 1 && cpu_rd_ack === 1, "R7", LINE_W'(nwb), LINE_W'(1));
    // R4 early write cancels C
    lat = 0;
    offer(26'h0C0, 12, 1, 1, 5); cyc();
    cyc();
    snoop(26'h0C0, 1, 1); cyc();
    miss_done = 1; cyc();
    repeat (3) cyc();
    #1 chk(nwb == 1 && mem_req === 0 && cpu_rd_ack === 1, "R4", LINE_W'(nwb), LINE_W'(1));
    // R4 write to another address does not cancel D
    offer(26'h0D0, 13, 1, 1, 6); cyc();
    snoop(26'h0D1, 1, 1); cyc();
    miss_done = 1; cyc();
    repeat (2) cyc();
    #1 chk(nwb == 2, "R4", LINE_W'(nwb), LINE_W'(2));
    // R8 older snoop: capture kept
    offer(26'h0E0, 14, 1, 1, 5); snoop(26'h0E0, 1, 2); cyc();
    #1 chk(cpu_rd_ack === 0, "R8", LINE_W'(cpu_rd_ack), LINE_W'(0));
    miss_done = 1; cyc();
    repeat (2) cyc();
    // R8 newer and equal snoop: capture discarded
    offer(26'h0F0, 15, 1, 1, 3); snoop(26'h0F0, 1, 7); cyc();
    #1 chk(cpu_rd_ack === 1, "R8", LINE_W'(cpu_rd_ack), LINE_W'(1));
    offer(26'h0F1, 16, 1, 1, 4); snoop(26'h0F1, 1, 4); cyc();
    #1 chk(cpu_rd_ack === 1, "R8", LINE_W'(cpu_rd_ack), LINE_W'(1));
    // R6 no request: ack low regardless of entry
    cpu_rd_req = 0;
    offer(26'h0A5, 17, 1, 1, 1); cyc();
    #1 chk(cpu_rd_ack === 0, "R6", LINE_W'(cpu_rd_ack), LINE_W'(0));
    cpu_rd_req = 1;
    miss_done = 1; cyc();
    repeat (3) cyc();
    chk(nwb == 4, "R7", LINE_W'(nwb), LINE_W'(4));
    chk(wb_log.size() == 4 && wb_log[0] == 26'h0A0 && wb_log[1] == 26'h0D0 && wb_log[2] == 26'h0E0,
        "R8", LINE_W'(wb_log.size()), LINE_W'(4));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule